// File: doc/BRIEF.md
# Configurable GPIO Pin Bank

This block controls thirteen general-purpose pins, organised as three groups of seven, four and two pins (pins 0-6, 7-10 and 11-12). Each pin has two byte-wide control registers on a simple synchronous register bus: a drive byte and a sense byte.

The drive byte sets these fields for the pin's pad:
- direction;
- push-pull or open-drain drive;
- pull enable;
- pull strength and pull direction;
- output value.

The sense byte returns the pin level after a two-flop synchronizer. It also selects which edges of that synchronized level raise a one-cycle event on the pin's own event output.

The register bus has no flow control. A write with `bus_we` high lands on the next rising clock edge. `bus_rdata` is a combinational view of the addressed register, so it can never stall or apply back-pressure. The pad outputs follow the drive bytes combinationally.

Top module: `gpio_pin_bank`

## Requirements
- R1: The drive byte of pin i sits at address i and its sense byte at address 13+i, for i = 0..12. A write changes only the addressed register.
- R2: A drive byte reads back bits 5:0 as written and bits 7:6 as zero. A sense byte reads back bits 2:1 as written, bit 0 as the level, and bits 7:3 as zero.
- R3: Drive byte bit 4 = 1 selects push-pull. In push-pull, `pad_oe` equals bit 5 (1 = output), `pad_out` equals bit 0, and `pad_od` is 0.
- R4: Drive byte bit 4 = 0 selects open-drain, with `pad_od` = 1 and `pad_out` = 0. In open-drain, `pad_oe` is 1 only when bit 5 = 1 and bit 0 = 0.
- R5: `pull_en` equals drive byte bit 3. Bits 2:1 encode the pull: 00 strong down, 01 strong up, 10 weak down, 11 weak up. `pull_up` equals bit 1 and `pull_weak` equals bit 2.
- R6: Sense byte bit 0 shows `pad_in` after two clock edges. Writes to bit 0 are ignored.
- R7: Sense byte bits 2:1 select event detection: 00 off, 01 falling, 10 rising, 11 both. A selected edge raises `edge_evt[i]` for exactly one cycle, starting two clock edges after `pad_in` changes. Other pins' events stay low.
- R8: Addresses 26 to 31 read as zero, and writes to them change no register or pad output.
- R9: Reset clears every drive byte and every detect field. All pins then come up as open-drain inputs with pulls off and no events.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write enable |
| bus_rdata | output | 8 | Read data of the addressed register |
| pad_in | input | 13 | Pin levels from the pads |
| pad_out | output | 13 | Output value to the pads |
| pad_oe | output | 13 | Output enable to the pads |
| pad_od | output | 13 | Open-drain mode indicator |
| pull_en | output | 13 | Pull resistor enable |
| pull_up | output | 13 | Pull direction, 1 = up |
| pull_weak | output | 13 | Pull strength, 1 = weak |
| edge_evt | output | 13 | One-cycle edge event per pin |

## Verification
The hardest cases to reach are those that tie the synchronizer to register state. One is a write of 0 to sense bit 0 while the synchronized level is high. Another is an edge that must produce no event because the detect field excludes it.

The stimulus toggles one pad for each of the four detect encodings. It samples the event vector exactly two edges after each pad change and again one cycle later, which catches a wrong latency and a stretched pulse. It raises a pad first and then writes the sense byte, so that the ignored write is observed with the level at 1.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  // drive byte layout, MSB first: dir, push_pull, pull_en, pull_weak, pull_up, value
  typedef struct packed {
    logic dir;
    logic push_pull;
    logic pull_en;
    logic pull_weak;
    logic pull_up;
    logic value;
  } drive_cfg_t;

  typedef enum logic [1:0] {
    DET_OFF  = 2'b00,
    DET_FALL = 2'b01,
    DET_RISE = 2'b10,
    DET_BOTH = 2'b11
  } detect_e;

  localparam int DRIVE_BITS = $bits(drive_cfg_t);
endpackage

// File: rtl/gpio_sync_edge.sv
module gpio_sync_edge
  import gpio_bank_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    pad_in,
  input  detect_e detect,
  output logic    level,
  output logic    evt
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= pad_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  logic rose, fell;
  assign rose  = sync_q & ~prev_q;
  assign fell  = ~sync_q & prev_q;
  assign level = sync_q;

  always_comb begin
    unique case (detect)
      DET_FALL: evt = fell;
      DET_RISE: evt = rose;
      DET_BOTH: evt = rose | fell;
      default:  evt = 1'b0;
    endcase
  end
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
  import gpio_bank_pkg::*;
(
  input  drive_cfg_t cfg,
  output logic       out,
  output logic       oe,
  output logic       od,
  output logic       pen,
  output logic       pup,
  output logic       pweak
);
  // open-drain: only ever pulls low; push-pull: enable follows direction
  assign oe    = cfg.dir & (cfg.push_pull | ~cfg.value);
  assign out   = cfg.push_pull & cfg.value;
  assign od    = ~cfg.push_pull;
  assign pen   = cfg.pull_en;
  assign pup   = cfg.pull_up;
  assign pweak = cfg.pull_weak;
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 13,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_PINS-1:0] level,
  output drive_cfg_t        drive_o  [NUM_PINS],
  output detect_e           detect_o [NUM_PINS]
);
  localparam int SENSE_BASE = NUM_PINS;

  drive_cfg_t drive_q  [NUM_PINS];
  detect_e    detect_q [NUM_PINS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_PINS; i++) begin
        drive_q[i]  <= '0;
        detect_q[i] <= DET_OFF;
      end
    end else if (bus_we) begin
      for (int i = 0; i < NUM_PINS; i++) begin
        if (int'(bus_addr) == i)
          drive_q[i] <= drive_cfg_t'(bus_wdata[DRIVE_BITS-1:0]);
        if (int'(bus_addr) == SENSE_BASE + i)
          detect_q[i] <= detect_e'(bus_wdata[2:1]);
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (int'(bus_addr) == i)
        bus_rdata = DATA_W'(drive_q[i]);
      if (int'(bus_addr) == SENSE_BASE + i)
        bus_rdata = DATA_W'({detect_q[i], level[i]});
    end
  end

  assign drive_o  = drive_q;
  assign detect_o = detect_q;
endmodule

// File: rtl/gpio_pin_bank.sv
module gpio_pin_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 13,
  parameter int DATA_W   = 8,
  localparam int ADDR_W  = $clog2(2 * NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic                bus_we,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pad_od,
  output logic [NUM_PINS-1:0] pull_en,
  output logic [NUM_PINS-1:0] pull_up,
  output logic [NUM_PINS-1:0] pull_weak,
  output logic [NUM_PINS-1:0] edge_evt
);
  drive_cfg_t          drive  [NUM_PINS];
  detect_e             detect [NUM_PINS];
  logic [NUM_PINS-1:0] level;

  gpio_ctrl_regs #(
    .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_rdata(bus_rdata), .level(level),
    .drive_o(drive), .detect_o(detect)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    gpio_sync_edge u_sense (
      .clk(clk), .rst(rst), .pad_in(pad_in[g]), .detect(detect[g]),
      .level(level[g]), .evt(edge_evt[g])
    );
    gpio_pad_drive u_drive (
      .cfg(drive[g]), .out(pad_out[g]), .oe(pad_oe[g]), .od(pad_od[g]),
      .pen(pull_en[g]), .pup(pull_up[g]), .pweak(pull_weak[g])
    );
  end
endmodule

// File: rtl/gpio_pin_bank_chk.sv
module gpio_pin_bank_chk #(
  parameter int NUM_PINS = 13,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 5
) (
  input logic                clk,
  input logic                rst,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic                bus_we,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic [NUM_PINS-1:0] pad_out,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic [NUM_PINS-1:0] pad_od,
  input logic [NUM_PINS-1:0] pull_en
);
  // R2
  drive_readback_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && int'(bus_addr) < NUM_PINS) |=>
      (bus_addr != $past(bus_addr) || bus_rdata[5:0] == $past(bus_wdata[5:0])));

  // R2
  top_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(bus_addr) < 2 * NUM_PINS) |-> bus_rdata[DATA_W-1:6] == '0);

  // R8
  unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(bus_addr) >= 2 * NUM_PINS) |-> bus_rdata == '0);

  // R9
  reset_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pad_oe == '0 && pull_en == '0 && pad_od == '1));

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    // R4
    od_never_high_chk: assert property (@(posedge clk) disable iff (rst)
      pad_od[g] |-> !pad_out[g]);
  end
endmodule

bind gpio_pin_bank gpio_pin_bank_chk #(
  .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .bus_rdata(bus_rdata), .pad_out(pad_out),
  .pad_oe(pad_oe), .pad_od(pad_od), .pull_en(pull_en)
);

// File: tb/gpio_pin_bank_bench.sv
module gpio_pin_bank_bench;
  localparam int N = 13;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [4:0]   bus_addr = '0;
  logic [7:0]   bus_wdata = '0;
  logic         bus_we = 1'b0;
  logic [7:0]   bus_rdata;
  logic [N-1:0] pad_in = '0;
  logic [N-1:0] pad_out, pad_oe, pad_od, pull_en, pull_up, pull_weak, edge_evt;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  gpio_pin_bank u_gpio_pin_bank (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od),
    .pull_en(pull_en), .pull_up(pull_up), .pull_weak(pull_weak),
    .edge_evt(edge_evt)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = 5'(a); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int a, input logic [7:0] exp);
    bus_addr = 5'(a);
    #1;
    chk(req, 32'(bus_rdata), 32'(exp));
  endtask

  task automatic test_reset();
    rd_chk("R9 drive byte", 0, 8'h00);
    rd_chk("R9 sense byte", 13, 8'h00);
    chk("R9 oe", 32'(pad_oe), 0);
    chk("R9 od", 32'(pad_od), 32'h1FFF);
    chk("R9 pull", 32'(pull_en), 0);
    chk("R9 evt", 32'(edge_evt), 0);
  endtask

  task automatic test_layout();
    wr(12, 8'hFF);
    rd_chk("R2 drive readback", 12, 8'h3F);
    rd_chk("R1 neighbour sense", 25, 8'h00);
    rd_chk("R1 neighbour drive", 11, 8'h00);
    wr(16, 8'hFF);
    rd_chk("R2 sense readback", 16, 8'h06);
    rd_chk("R1 pin3 drive untouched", 3, 8'h00);
    wr(16, 8'h00);
    wr(12, 8'h00);
  endtask

  task automatic test_push_pull();
    wr(0, 8'h31);
    chk("R3 oe", 32'(pad_oe[0]), 1);
    chk("R3 out", 32'(pad_out[0]), 1);
    chk("R3 od", 32'(pad_od[0]), 0);
    wr(0, 8'h30);
    chk("R3 out low", 32'(pad_out[0]), 0);
    chk("R3 oe low value", 32'(pad_oe[0]), 1);
    wr(0, 8'h11);
    chk("R3 input no oe", 32'(pad_oe[0]), 0);
  endtask

  task automatic test_open_drain();
    wr(7, 8'h20);
    chk("R4 drive low oe", 32'(pad_oe[7]), 1);
    chk("R4 out", 32'(pad_out[7]), 0);
    chk("R4 od", 32'(pad_od[7]), 1);
    wr(7, 8'h21);
    chk("R4 release", 32'(pad_oe[7]), 0);
    wr(7, 8'h01);
    chk("R4 input", 32'(pad_oe[7]), 0);
  endtask

  task automatic test_pull();
    wr(5, 8'h0A);
    chk("R5 en strong up", 32'({pull_en[5], pull_weak[5], pull_up[5]}), 3'b101);
    wr(5, 8'h0C);
    chk("R5 en weak down", 32'({pull_en[5], pull_weak[5], pull_up[5]}), 3'b110);
    wr(5, 8'h06);
    chk("R5 disabled weak up", 32'({pull_en[5], pull_weak[5], pull_up[5]}), 3'b011);
  endtask

  task automatic test_level();
    @(negedge clk);
    bus_addr = 5'd22;
    pad_in[9] = 1'b1;
    #1 chk("R6 level t0", 32'(bus_rdata[0]), 0);
    @(negedge clk);
    chk("R6 level after 1 edge", 32'(bus_rdata[0]), 0);
    @(negedge clk);
    chk("R6 level after 2 edges", 32'(bus_rdata[0]), 1);
    wr(22, 8'h00);
    rd_chk("R6 bit0 write ignored", 22, 8'h01);
    chk("R7 off no event", 32'(edge_evt), 0);
  endtask

  task automatic edge_run(input logic [1:0] det, input logic exp_rise, input logic exp_fall);
    wr(15, {5'b0, det, 1'b0});
    @(negedge clk) pad_in[2] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R7 rise event", 32'(edge_evt), exp_rise ? 32'h4 : 32'h0);
    @(negedge clk);
    chk("R7 rise one cycle", 32'(edge_evt), 0);
    pad_in[2] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R7 fall event", 32'(edge_evt), exp_fall ? 32'h4 : 32'h0);
    @(negedge clk);
    chk("R7 fall one cycle", 32'(edge_evt), 0);
  endtask

  task automatic test_edges();
    edge_run(2'b00, 1'b0, 1'b0);
    edge_run(2'b01, 1'b0, 1'b1);
    edge_run(2'b10, 1'b1, 1'b0);
    edge_run(2'b11, 1'b1, 1'b1);
  endtask

  task automatic test_unmapped();
    logic [N-1:0] oe_s, pe_s;
    oe_s = pad_oe; pe_s = pull_en;
    wr(26, 8'hFF);
    wr(31, 8'hFF);
    rd_chk("R8 read 26", 26, 8'h00);
    rd_chk("R8 read 31", 31, 8'h00);
    chk("R8 oe unchanged", 32'(pad_oe), 32'(oe_s));
    chk("R8 pull unchanged", 32'(pull_en), 32'(pe_s));
    rd_chk("R8 pin0 drive unchanged", 0, 8'h11);
    rd_chk("R8 pin0 sense unchanged", 13, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    test_reset();
    test_layout();
    test_push_pull();
    test_open_drain();
    test_pull();
    test_level();
    test_edges();
    test_unmapped();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule